// File: doc/BRIEF.md
# Memory Guard Segment Configuration Bank

This block is the configuration register bank for a memory guard that watches bus traffic into three protected regions: a code region, a non-volatile data region and a volatile data region. Software programs a base and a size for each region and the attributes of the volatile region, then arms the guard with a sticky enable bit. The bank drives these values to a separate access monitor. It also takes the monitor's present state as an input so that it can police accesses to its own control register.

Each region is aligned to its own block size, and the low address bits below that size always read as zero. Once the guard is armed, the region geometry and the volatile-region attributes are locked. Only the prearm bit stays writable, so protected code can still signal a clean exit. While the monitor is closed, any touch of the control register is refused and reported as a reset request. The exception is an empty non-volatile region, which removes that restriction.

Top module: `fwcfg_regs`

## Requirements
- R1: After a synchronous reset every region base and size, the control bits and the enable read as 0 and drive 0 on their ports, and `bus_rdata` and `reset_req` are 0.
- R2: The bank forces bits [7:0] of the code and non-volatile base and size to zero, and bits [5:0] of the volatile base and size. Register words are: 0 code base, 1 code size, 2 non-volatile base, 3 non-volatile size, 4 volatile base, 5 volatile size, 6 control, 7 enable. A read returns the aligned value.
- R3: Writing 1 to bit 0 of word 7 sets `guard_on`. Later writes of 0 leave it set until reset, and word 7 reads back `guard_on` in bit 0.
- R4: While `guard_on` is 1, writes to words 0 to 5 have no effect.
- R5: The control word holds prearm in bit 0, volatile shared in bit 1 and volatile executable in bit 2. Shared and executable can only change while `guard_on` is 0. Prearm stays writable.
- R6: Monitor states are encoded as 2'b00 idle, 2'b01 closed and 2'b10 open. A read or write of word 6 while the state is closed and the non-volatile size is non-zero changes nothing and reads 0. It raises `reset_req` for exactly one cycle, in the cycle after the access.
- R7: Word 6 is readable and writable in the idle and open states. It is readable and writable in any state when the non-volatile size is 0. `reset_req` is never raised without a preceding refused access.
- R8: Read data appears on `bus_rdata` in the cycle after the read request and is 0 in cycles without a read. A read issued in the cycle right after a write returns the written value.
- R9: Words 8 to 15 are unmapped. They read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus transfer request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_word | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mon_state | input | 2 | Access monitor state (00 idle, 01 closed, 10 open) |
| code_base | output | 32 | Code region base |
| code_size | output | 32 | Code region size |
| nvd_base | output | 32 | Non-volatile region base |
| nvd_size | output | 32 | Non-volatile region size |
| vol_base | output | 32 | Volatile region base |
| vol_size | output | 32 | Volatile region size |
| vol_shared | output | 1 | Volatile region shared attribute |
| vol_exec | output | 1 | Volatile region executable attribute |
| prearm | output | 1 | Prearm bit |
| guard_on | output | 1 | Sticky guard enable |
| reset_req | output | 1 | One-cycle request for a system reset |

## Verification
The assertions check the following on every cycle:
- alignment of all six geometry outputs;
- stickiness of the enable;
- freezing of the geometry and the volatile attributes once armed;
- the exact pairing between refused control accesses and `reset_req` pulses;
- zero data for unmapped reads.

The values that software observes need the bench's scenarios. These are aligned readback of chosen addresses, a write followed at once by a read of prearm, refusal in the closed state, and the lifted restriction with an empty non-volatile region after a fresh reset.

// File: rtl/fwcfg_pkg.sv
package fwcfg_pkg;

    localparam int DATA_W  = 32;
    localparam int IDX_W   = 4;
    localparam int NUM_SEG = 3;

    localparam logic [IDX_W-1:0] IDX_CTRL   = 4'd6;
    localparam logic [IDX_W-1:0] IDX_ENABLE = 4'd7;
    localparam logic [IDX_W-1:0] IDX_LAST   = 4'd7;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'b00,
        MON_CLOSE = 2'b01,
        MON_OPEN  = 2'b10
    } mon_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] size;
    } seg_cfg_t;

    typedef struct packed {
        logic vexec;
        logic vshared;
        logic prearm;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] align_down(input logic [DATA_W-1:0] v,
                                                     input int unsigned bits);
        logic [DATA_W-1:0] one;
        one = 1;
        return v & ~((one << bits) - one);
    endfunction

endpackage

// File: rtl/fwcfg_seg_reg.sv
module fwcfg_seg_reg
    import fwcfg_pkg::*;
#(
    parameter int unsigned GRAN_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic              wr_base,
    input  logic              wr_size,
    input  logic [DATA_W-1:0] wdata,
    output seg_cfg_t          cfg
);

    logic [DATA_W-1:0] aligned;
    assign aligned = align_down(wdata, GRAN_BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (!lock) begin
            if (wr_base) cfg.base <= aligned;
            if (wr_size) cfg.size <= aligned;
        end
    end

endmodule

// File: rtl/fwcfg_ctrl.sv
module fwcfg_ctrl
    import fwcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_acc,
    input  logic       ctrl_wr,
    input  ctrl_t      ctrl_wdata,
    input  logic       en_wr,
    input  logic       en_bit,
    input  logic [1:0] mon_state,
    input  logic       nvd_empty,
    output ctrl_t      ctrl,
    output logic       guard_on,
    output logic       ctrl_ok,
    output logic       reset_req
);

    assign ctrl_ok = (mon_state != MON_CLOSE) || nvd_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            guard_on  <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            if (en_wr && en_bit) guard_on <= 1'b1;
            if (ctrl_acc && ctrl_wr && ctrl_ok) begin
                ctrl.prearm <= ctrl_wdata.prearm;
                if (!guard_on) begin
                    ctrl.vshared <= ctrl_wdata.vshared;
                    ctrl.vexec   <= ctrl_wdata.vexec;
                end
            end
            reset_req <= ctrl_acc && !ctrl_ok;
        end
    end

endmodule

// File: rtl/fwcfg_regs.sv
module fwcfg_regs
    import fwcfg_pkg::*;
#(
    parameter int unsigned CODE_GRAN = 8,
    parameter int unsigned NVD_GRAN  = 8,
    parameter int unsigned VOL_GRAN  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [IDX_W-1:0]  bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        mon_state,
    output logic [DATA_W-1:0] code_base,
    output logic [DATA_W-1:0] code_size,
    output logic [DATA_W-1:0] nvd_base,
    output logic [DATA_W-1:0] nvd_size,
    output logic [DATA_W-1:0] vol_base,
    output logic [DATA_W-1:0] vol_size,
    output logic              vol_shared,
    output logic              vol_exec,
    output logic              prearm,
    output logic              guard_on,
    output logic              reset_req
);

    localparam int unsigned SEG_GRAN [NUM_SEG] = '{CODE_GRAN, NVD_GRAN, VOL_GRAN};

    bus_req_t req;
    seg_cfg_t seg [NUM_SEG];
    ctrl_t    ctrl;
    logic     ctrl_ok;
    logic [DATA_W-1:0] rd_val;

    assign req = '{valid: bus_valid, write: bus_write, idx: bus_word, wdata: bus_wdata};

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        fwcfg_seg_reg #(.GRAN_BITS(SEG_GRAN[s])) u_seg (
            .clk    (clk),
            .rst    (rst),
            .lock   (guard_on),
            .wr_base(req.valid && req.write && req.idx == IDX_W'(2*s)),
            .wr_size(req.valid && req.write && req.idx == IDX_W'(2*s+1)),
            .wdata  (req.wdata),
            .cfg    (seg[s])
        );
    end

    fwcfg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_acc  (req.valid && req.idx == IDX_CTRL),
        .ctrl_wr   (req.write),
        .ctrl_wdata(ctrl_t'(req.wdata[2:0])),
        .en_wr     (req.valid && req.write && req.idx == IDX_ENABLE),
        .en_bit    (req.wdata[0]),
        .mon_state (mon_state),
        .nvd_empty (seg[1].size == '0),
        .ctrl      (ctrl),
        .guard_on  (guard_on),
        .ctrl_ok   (ctrl_ok),
        .reset_req (reset_req)
    );

    always_comb begin
        rd_val = '0;
        if (req.idx < IDX_W'(2*NUM_SEG)) begin
            for (int s = 0; s < NUM_SEG; s++) begin
                if (req.idx == IDX_W'(2*s))   rd_val = seg[s].base;
                if (req.idx == IDX_W'(2*s+1)) rd_val = seg[s].size;
            end
        end else if (req.idx == IDX_CTRL) begin
            rd_val = ctrl_ok ? DATA_W'(ctrl) : '0;
        end else if (req.idx == IDX_ENABLE) begin
            rd_val = DATA_W'(guard_on);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= (req.valid && !req.write) ? rd_val : '0;
    end

    assign code_base  = seg[0].base;
    assign code_size  = seg[0].size;
    assign nvd_base   = seg[1].base;
    assign nvd_size   = seg[1].size;
    assign vol_base   = seg[2].base;
    assign vol_size   = seg[2].size;
    assign vol_shared = ctrl.vshared;
    assign vol_exec   = ctrl.vexec;
    assign prearm     = ctrl.prearm;

endmodule

// File: rtl/fwcfg_chk.sv
module fwcfg_chk
    import fwcfg_pkg::*;
#(
    parameter int unsigned CODE_GRAN = 8,
    parameter int unsigned NVD_GRAN  = 8,
    parameter int unsigned VOL_GRAN  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [IDX_W-1:0]  bus_word,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        mon_state,
    input logic [DATA_W-1:0] code_base,
    input logic [DATA_W-1:0] code_size,
    input logic [DATA_W-1:0] nvd_base,
    input logic [DATA_W-1:0] nvd_size,
    input logic [DATA_W-1:0] vol_base,
    input logic [DATA_W-1:0] vol_size,
    input logic              vol_shared,
    input logic              vol_exec,
    input logic              prearm,
    input logic              guard_on,
    input logic              reset_req
);

    logic refused;
    assign refused = bus_valid && bus_word == IDX_CTRL &&
                     mon_state == MON_CLOSE && nvd_size != '0;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!guard_on && !reset_req && bus_rdata == '0 && !prearm &&
                        code_base == '0 && nvd_size == '0 && vol_size == '0));

    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        code_base[CODE_GRAN-1:0] == '0 && code_size[CODE_GRAN-1:0] == '0 &&
        nvd_base[NVD_GRAN-1:0] == '0 && nvd_size[NVD_GRAN-1:0] == '0 &&
        vol_base[VOL_GRAN-1:0] == '0 && vol_size[VOL_GRAN-1:0] == '0);

    p_sticky_enable_r3: assert property (@(posedge clk) disable iff (rst)
        $past(guard_on) |-> guard_on);

    p_geometry_locked_r4: assert property (@(posedge clk) disable iff (rst)
        $past(guard_on) |-> ($stable(code_base) && $stable(code_size) &&
                             $stable(nvd_base) && $stable(nvd_size) &&
                             $stable(vol_base) && $stable(vol_size)));

    p_attr_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        $past(guard_on) |-> ($stable(vol_shared) && $stable(vol_exec)));

    p_refused_access_r6: assert property (@(posedge clk) disable iff (rst)
        $past(refused) |-> (reset_req && $stable(prearm) && bus_rdata == '0));

    p_no_spurious_req_r7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(refused));

    p_idle_rdata_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!(bus_valid && !bus_write)) |-> bus_rdata == '0);

    p_unmapped_read_r9: assert property (@(posedge clk) disable iff (rst)
        $past(bus_valid && !bus_write && bus_word > IDX_LAST) |-> bus_rdata == '0);

endmodule

bind fwcfg_regs fwcfg_chk #(
    .CODE_GRAN(CODE_GRAN),
    .NVD_GRAN (NVD_GRAN),
    .VOL_GRAN (VOL_GRAN)
) u_chk (.*);

// File: tb/tb_fwcfg_regs.sv
`timescale 1ns/1ps
module tb_fwcfg_regs;
    import fwcfg_pkg::*;

    localparam real PERIOD = 8.0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [IDX_W-1:0]  bus_word = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [1:0]        mon_state = 2'b00;
    logic [DATA_W-1:0] code_base, code_size, nvd_base, nvd_size, vol_base, vol_size;
    logic              vol_shared, vol_exec, prearm, guard_on, reset_req;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    always #(PERIOD/2) clk = ~clk;

    fwcfg_regs dut (.*);

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_op(logic w, logic [IDX_W-1:0] idx, logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_word = idx; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(logic [IDX_W-1:0] idx, logic [DATA_W-1:0] d);
        bus_op(1'b1, idx, d);
    endtask

    task automatic rd(logic [IDX_W-1:0] idx, logic [DATA_W-1:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_op(1'b0, idx, '0);
    endtask

    // write then read in the very next cycle
    task automatic wr_rd(logic [IDX_W-1:0] idx, logic [DATA_W-1:0] d,
                         logic [DATA_W-1:0] exp, string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = idx; bus_wdata = d;
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_write = 1'b0;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: compares registered read data against the scoreboard queue
    always @(posedge clk) begin
        logic was_rd;
        was_rd = bus_valid && !bus_write && !rst;
        #2;
        if (was_rd) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected read", bus_rdata, '0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 guard_on", guard_on, 0);
        check("R1 reset_req", reset_req, 0);
        check("R1 rdata", bus_rdata, 0);
        check("R1 code_base", code_base, 0);
        for (int i = 0; i < 8; i++) rd(IDX_W'(i), 0, "R1 register reads zero");

        // R2 alignment per region
        mon_state = MON_IDLE;
        wr(0, 32'h0800_51FF); rd(0, 32'h0800_5100, "R2 code base");
        wr(1, 32'h0000_12FF); rd(1, 32'h0000_1200, "R2 code size");
        wr(2, 32'h0801_0080); rd(2, 32'h0801_0000, "R2 nvd base");
        wr(3, 32'h0000_04FF); rd(3, 32'h0000_0400, "R2 nvd size");
        wr(4, 32'h2000_107F); rd(4, 32'h2000_1040, "R2 vol base");
        wr(5, 32'h0000_00FF); rd(5, 32'h0000_00C0, "R2 vol size");
        check("R2 vol_base port", vol_base, 32'h2000_1040);
        check("R2 nvd_size port", nvd_size, 32'h0000_0400);

        // R7 control access in idle
        wr(6, 32'h6); rd(6, 32'h6, "R7 ctrl idle");
        check("R5 vol_shared", vol_shared, 1);
        check("R5 vol_exec", vol_exec, 1);

        // R9 unmapped
        wr(8, 32'hFFFF_FFFF);
        rd(8, 0, "R9 unmapped 8");
        rd(15, 0, "R9 unmapped 15");
        rd(0, 32'h0800_5100, "R9 code base untouched");

        // R3 sticky enable
        wr(7, 32'h0);
        check("R3 zero write keeps off", guard_on, 0);
        wr(7, 32'h1);
        check("R3 guard set", guard_on, 1);
        wr(7, 32'h0);
        check("R3 guard sticky", guard_on, 1);
        rd(7, 32'h1, "R3 enable readback");

        // R4 geometry locked
        wr(0, 32'h1234_5600); rd(0, 32'h0800_5100, "R4 code base locked");
        wr(5, 32'h0000_1000); rd(5, 32'h0000_00C0, "R4 vol size locked");

        // R6 refused in closed state
        mon_state = MON_CLOSE;
        rd(6, 0, "R6 closed read returns 0");
        check("R6 reset_req after read", reset_req, 1);
        @(negedge clk);
        check("R6 reset_req one cycle", reset_req, 0);
        wr(6, 32'h1);
        check("R6 reset_req after write", reset_req, 1);
        check("R6 prearm unchanged", prearm, 0);

        // R5/R8 open state, back-to-back readback
        mon_state = MON_OPEN;
        wr_rd(6, 32'h1, 32'h7, "R8 prearm readback, R5 attrs frozen");
        check("R7 no reset_req in open", reset_req, 0);
        wr_rd(6, 32'h0, 32'h6, "R5 prearm clears");
        check("R5 vol_shared frozen", vol_shared, 1);

        // R7 empty nvd region lifts restriction
        do_reset();
        mon_state = MON_IDLE;
        wr(0, 32'h0800_0000);
        wr(7, 32'h1);
        mon_state = MON_CLOSE;
        wr(6, 32'h1);
        check("R7 no reset_req with empty nvd", reset_req, 0);
        rd(6, 32'h1, "R7 closed access with empty nvd");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule